// File: doc/BRIEF.md
# Banked Register-Mapped GPIO Controller

This block gives software control over a configurable number of general-purpose pins (a multiple of 32) through a plain 32-bit register bus. Every pin can be read back, switched between input and output, driven high or low with write-one set and clear words, watched for rising and/or falling edges, and given a 2-bit alternate-function code. Detected edges latch into sticky status bits that software clears by writing ones, and a single interrupt line is raised while any status bit is set.

Registers are grouped by kind. Each kind owns a block of NUM_PINS/32 consecutive 32-bit words, and the kinds follow one another in a fixed order, so the byte address of word r of kind k is k*(NUM_PINS/32)*4 + r*4. Pin p lives in word p/32 at bit p%32. The alternate-function block comes last and is twice as long, because each pin takes two bits in it. Pin inputs are synchronised before use, and edges are found by comparing the synchronised level against its value one cycle earlier.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Reading a level word (kind 0) returns the synchronised state of the pins it covers. A change on `pin_in` becomes visible after two clock edges.
- R2: Writes to level words are ignored, and a later read still returns the pin state.
- R3: Direction words (kind 1) read back as written. Bit value 1 asserts `pin_oe` for that pin, and bit value 0 makes the pin an input.
- R4: Writing a 1 to a bit of a set word (kind 2) drives that pin's `pin_out` high. Writing a 1 to a bit of a clear word (kind 3) drives it low. Zero bits leave the output unchanged, and both kinds read as 0.
- R5: Rising-enable words (kind 4) and falling-enable words (kind 5) act independently per pin: rising only, falling only, either edge, or none.
- R6: A status bit (kind 6) latches on an enabled edge and stays set. Writing 1 clears it, and writing 0 leaves it unchanged.
- R7: If an enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R8: `irq` is high exactly when at least one status bit is set. It rises on the third clock edge after a pin change, and it is still low after the second edge.
- R9: Alternate-function words (kind 7, 2*NUM_PINS/32 words) place pin p in word p/16 at bits 2*(p%16)+1 to 2*(p%16). Each field is driven on `pin_alt[2p+1:2p]` and reads back as written.
- R10: Addresses follow k*(NUM_PINS/32)*4 + r*4. A read asserted in one cycle returns its data with `bus_rvalid` on the next cycle.
- R11: After reset every direction bit, enable bit, status bit, output bit and alternate-function field is 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_alt | output | 2*NUM_PINS | Per-pin alternate-function code |
| irq | output | 1 | Any status bit set |

## Verification
Register writes take effect on the clock edge that samples the strobe. Read data is captured on the edge that samples `bus_rd`, so the bench reads it at the following falling edge. A pin change reaches the level readback two edges later, and it reaches the status and `irq` one edge after that. The bench checks `irq` at the falling edges either side of that third edge. For the clash between a new edge and a clear, the bench lines up the clear write with the edge on which the status bit would latch. In all other cases the bench waits out the full pipeline before it reads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6,
    RK_ALT   = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic        valid;
    reg_kind_e   kind;
    logic [15:0] idx;
  } reg_dec_t;

  // Word address -> register kind and word index within the kind's block.
  function automatic reg_dec_t decode_word(input int unsigned word, input int unsigned nw);
    reg_dec_t d;
    d.valid = 1'b0;
    d.kind  = RK_LEVEL;
    d.idx   = '0;
    if (word < 7 * nw) begin
      d.valid = 1'b1;
      d.kind  = reg_kind_e'(3'(word / nw));
      d.idx   = 16'(word % nw);
    end else if (word < 9 * nw) begin
      d.valid = 1'b1;
      d.kind  = RK_ALT;
      d.idx   = 16'(word - 7 * nw);
    end
    return d;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;
  logic [W-1:0] rise_w;
  logic [W-1:0] fall_w;

  assign rise_w = lvl_i & ~prev_q;
  assign fall_w = ~lvl_i & prev_q;
  assign hit_o  = (rise_w & rise_en_i) | (fall_w & fall_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | hit_o;
    end
  end

  assign status_o = stat_q;

  // R7: a fresh event is never lost, even against a simultaneous clear
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o != '0) |=> ((status_o & $past(hit_o)) == $past(hit_o)));

  // R6: a clear with no competing event empties the bit
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~hit_o) != '0) |=> ((status_o & $past(clr_i & ~hit_o)) == '0));

  // R6: set bits not being cleared stay set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [2*NUM_PINS-1:0] pin_alt,
  output logic                  irq
);
  localparam int NW = NUM_PINS / 32;

  logic [NUM_PINS-1:0]   lvl_w;
  logic [NUM_PINS-1:0]   dir_q, out_q, ren_q, fen_q;
  logic [2*NUM_PINS-1:0] alt_q;
  logic [NUM_PINS-1:0]   set_mask, clr_mask, stat_clr;
  logic [NUM_PINS-1:0]   hit_all, stat_all;
  logic [31:0]           rd_word, rdata_q;
  logic                  rvalid_q;
  reg_dec_t              dec;
  int unsigned           ix;

  gpio_pin_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(lvl_w)
  );

  for (genvar b = 0; b < NW; b++) begin : g_bank
    gpio_edge_track #(.W(32)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl_w[b*32 +: 32]),
      .rise_en_i(ren_q[b*32 +: 32]),
      .fall_en_i(fen_q[b*32 +: 32]),
      .clr_i    (stat_clr[b*32 +: 32]),
      .hit_o    (hit_all[b*32 +: 32]),
      .status_o (stat_all[b*32 +: 32])
    );
  end

  always_comb begin
    dec = decode_word(32'(bus_addr[ADDR_W-1:2]), NW);
    ix  = 32'(dec.idx);
  end

  // write-one masks for set, clear and status
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    stat_clr = '0;
    if (bus_wr && dec.valid) begin
      case (dec.kind)
        RK_SET:  set_mask[ix*32 +: 32] = bus_wdata;
        RK_CLR:  clr_mask[ix*32 +: 32] = bus_wdata;
        RK_STAT: stat_clr[ix*32 +: 32] = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      alt_q <= '0;
    end else begin
      out_q <= (out_q | set_mask) & ~clr_mask;
      if (bus_wr && dec.valid) begin
        case (dec.kind)
          RK_DIR:  dir_q[ix*32 +: 32] <= bus_wdata;
          RK_RISE: ren_q[ix*32 +: 32] <= bus_wdata;
          RK_FALL: fen_q[ix*32 +: 32] <= bus_wdata;
          RK_ALT:  alt_q[ix*32 +: 32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (dec.valid) begin
      case (dec.kind)
        RK_LEVEL: rd_word = lvl_w[ix*32 +: 32];
        RK_DIR:   rd_word = dir_q[ix*32 +: 32];
        RK_RISE:  rd_word = ren_q[ix*32 +: 32];
        RK_FALL:  rd_word = fen_q[ix*32 +: 32];
        RK_STAT:  rd_word = stat_all[ix*32 +: 32];
        RK_ALT:   rd_word = alt_q[ix*32 +: 32];
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_word;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pin_oe     = dir_q;
  assign pin_out    = out_q;
  assign pin_alt    = alt_q;
  assign irq        = |stat_all;

  // R10: one-cycle read response
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R4: output only moves on a bus write
  a_r4_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out));

  // R3: direction only moves on a bus write
  a_r3_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe));

  // R8: interrupt can only rise after an enabled edge event
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit_all) != '0));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;
  localparam int NP = 64;
  localparam int NW = NP / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_oe, pin_out;
  logic [2*NP-1:0] pin_alt;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_alt(pin_alt), .irq(irq)
  );

  function automatic logic [11:0] adr(input int kind, input int word);
    return 12'(kind * NW * 4 + word * 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk(bus_rvalid === 1'b1, "R10 rvalid", 128'(bus_rvalid), 128'(1));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] m_out, pat;
    logic [2*NP-1:0] m_alt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(irq === 1'b0 && pin_oe === '0 && pin_out === '0 && pin_alt === '0, "R11 outputs",
        128'({irq, pin_oe, pin_out}), 128'(0));
    for (int k = 1; k < 7; k++) begin
      if (k == 2 || k == 3) continue;
      for (int r = 0; r < NW; r++) begin
        rd(adr(k, r), d);
        chk(d === 32'h0, "R11 register reset", 128'(d), 128'(0));
      end
    end
    for (int r = 0; r < 2*NW; r++) begin
      rd(adr(7, r), d);
      chk(d === 32'h0, "R11 alt reset", 128'(d), 128'(0));
    end

    // R1: level readback over several patterns
    for (int i = 0; i < 6; i++) begin
      pat = (i == 0) ? 64'hA5A5_0F0F_1234_8001 : (i == 1) ? ~64'hA5A5_0F0F_1234_8001 :
            (i == 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h1 << (i * 19);
      @(negedge clk); pin_in = pat;
      settle();
      for (int r = 0; r < NW; r++) begin
        rd(adr(0, r), d);
        chk(d === pat[r*32 +: 32], "R1 level readback (R10 address)", 128'(d), 128'(pat[r*32 +: 32]));
      end
    end
    // R2: writes to level ignored
    wr(adr(0, 0), ~pat[31:0]);
    wr(adr(0, 1), ~pat[63:32]);
    rd(adr(0, 0), d);
    chk(d === pat[31:0], "R2 level write ignored", 128'(d), 128'(pat[31:0]));
    rd(adr(0, 1), d);
    chk(d === pat[63:32], "R2 level write ignored", 128'(d), 128'(pat[63:32]));

    // R3: direction
    wr(adr(1, 0), 32'hDEAD_BEEF);
    wr(adr(1, 1), 32'h0F0F_00FF);
    @(negedge clk);
    chk(pin_oe === 64'h0F0F_00FF_DEAD_BEEF, "R3 pin_oe", 128'(pin_oe), 128'(64'h0F0F_00FF_DEAD_BEEF));
    rd(adr(1, 1), d);
    chk(d === 32'h0F0F_00FF, "R3 dir readback", 128'(d), 128'(32'h0F0F_00FF));

    // R4: single-bit set sweep, then pattern clears
    m_out = '0;
    for (int p = 0; p < NP; p += 3) begin
      wr(adr(2, p / 32), 32'h1 << (p % 32));
      m_out[p] = 1'b1;
      chk(pin_out === m_out, "R4 set bit", 128'(pin_out), 128'(m_out));
    end
    wr(adr(3, 1), 32'h5555_5555);
    m_out[63:32] = m_out[63:32] & ~32'h5555_5555;
    chk(pin_out === m_out, "R4 clear pattern", 128'(pin_out), 128'(m_out));
    wr(adr(2, 0), 32'h0);
    wr(adr(3, 0), 32'h0);
    chk(pin_out === m_out, "R4 zero writes no effect", 128'(pin_out), 128'(m_out));
    rd(adr(2, 0), d);
    chk(d === 32'h0, "R4 set word reads 0", 128'(d), 128'(0));

    // R5/R6/R8: per-pin edge sweep over all four enable modes
    @(negedge clk); pin_in = '0;
    settle();
    for (int mode = 0; mode < 4; mode++) begin
      for (int r = 0; r < NW; r++) begin
        wr(adr(4, r), mode[0] ? 32'hFFFF_FFFF : 32'h0);
        wr(adr(5, r), mode[1] ? 32'hFFFF_FFFF : 32'h0);
        wr(adr(6, r), 32'hFFFF_FFFF);
      end
      for (int p = 0; p < NP; p += 5) begin
        @(negedge clk); pin_in[p] = 1'b1;
        settle();
        rd(adr(6, p / 32), d);
        chk(d === (mode[0] ? 32'h1 << (p % 32) : 32'h0), "R5 rising detect", 128'(d),
            128'(mode[0] ? 32'h1 << (p % 32) : 32'h0));
        chk(irq === mode[0], "R8 irq after rise", 128'(irq), 128'(mode[0]));
        wr(adr(6, p / 32), 32'h1 << (p % 32));
        rd(adr(6, p / 32), d);
        chk(d === 32'h0 && irq === 1'b0, "R6 w1c", 128'(d), 128'(0));
        @(negedge clk); pin_in[p] = 1'b0;
        settle();
        rd(adr(6, p / 32), d);
        chk(d === (mode[1] ? 32'h1 << (p % 32) : 32'h0), "R5 falling detect", 128'(d),
            128'(mode[1] ? 32'h1 << (p % 32) : 32'h0));
        if (mode[1]) begin
          wr(adr(6, p / 32), 32'h0);
          rd(adr(6, p / 32), d);
          chk(d === 32'h1 << (p % 32), "R6 zero write keeps bit", 128'(d), 128'(32'h1 << (p % 32)));
        end
        wr(adr(6, p / 32), 32'h1 << (p % 32));
      end
    end

    // R8: exact irq timing (both edges enabled from last mode)
    settle();
    @(negedge clk); pin_in[40] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(irq === 1'b0, "R8 irq not before third edge", 128'(irq), 128'(0));
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq at third edge", 128'(irq), 128'(1));
    wr(adr(6, 1), 32'h1 << 8);
    @(negedge clk);
    chk(irq === 1'b0, "R8 irq drops when clear", 128'(irq), 128'(0));

    // R7: clear coincides with new edge on pin 5
    @(negedge clk); pin_in[5] = 1'b1;
    settle();
    @(negedge clk); pin_in[5] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = adr(6, 0); bus_wdata = 32'h1 << 5; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(adr(6, 0), d);
    chk(d[5] === 1'b1, "R7 event beats clear", 128'(d), 128'(32'h20));
    wr(adr(6, 0), 32'h1 << 5);
    rd(adr(6, 0), d);
    chk(d === 32'h0, "R7 later clear works", 128'(d), 128'(0));

    // R9: alternate-function packing
    m_alt = '0;
    for (int p = 0; p < NP; p++) m_alt[2*p +: 2] = 2'((p % 3) + 1);
    for (int w = 0; w < 2*NW; w++) begin
      logic [31:0] word;
      word = '0;
      for (int q = 0; q < 16; q++) word[2*q +: 2] = 2'(((w * 16 + q) % 3) + 1);
      wr(adr(7, w), word);
    end
    chk(pin_alt === m_alt, "R9 pin_alt packing", pin_alt, m_alt);
    rd(adr(7, 2), d);
    chk(d === m_alt[64 +: 32], "R9 alt readback", 128'(d), 128'(m_alt[64 +: 32]));
    wr(adr(7, 37 / 16), 32'h0);
    m_alt[32*2 +: 32] = '0;
    chk(pin_alt[75:74] === 2'b00 && pin_alt === m_alt, "R9 pin 37 field", pin_alt, m_alt);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule